// File: doc/BRIEF.md
# Critical-Word-First Line Fill Buffer

This block rebuilds one cache line from a read burst whose data beats come back rotated, so that the word the processor missed on arrives first and the rest follow in ascending word order, wrapping from the top of the line back to word 0. A fill starts with a one-cycle start strobe and a miss address. The block rounds that address down to word alignment and takes the starting word index from it. It then takes one beat per cycle over a valid/ready handshake that carries a last flag.

Each beat is written into its own word slot of a line register. The slot for beat n is (start index + n) modulo the words per line. The first beat is passed straight through to the requester in the same cycle, so the processor can resume before the line is complete. When the beat flagged last is also the final beat of the line, the block pulses a done strobe and presents the complete line and its aligned base address. A last flag at any other beat count ends the fill with a length-error pulse instead.

The line holds `LINE_WORDS` words of `WORD_W` bits. `LINE_WORDS` must be 2, 4, 8 or 16. `WORD_W` is a power of two of at least 16 bits. The line is aligned to its own size in bytes.

Top module: `cwf_line_fill`

## Requirements
- R1: Out of reset `busy_o`, `beat_ready_o`, `crit_valid_o`, `line_done_o` and `len_err_o` are 0, and `line_data_o` and `line_base_o` are all zeros.
- R2: A `start_i` pulse while idle begins a fill. From the next cycle `busy_o` is 1, and `line_base_o` equals `miss_addr_i` with its low log2(LINE_WORDS*WORD_W/8) bits cleared. The starting word index is taken from the address bits just above the byte offset, and the byte-offset bits below word size are ignored.
- R3: A `start_i` pulse while a fill is in progress is ignored. `line_base_o` keeps its value and the running fill ends with the slot placement of its original start.
- R4: `beat_ready_o` is 1 on every cycle of a fill, so a beat is accepted on each cycle that `beat_valid_i` is 1.
- R5: On the handshake of the first beat, and only then, `crit_valid_o` is 1 for that one cycle and `crit_data_o` equals `beat_data_i`.
- R6: Beat n of a fill is written to slot (s + n) mod LINE_WORDS, where s is the starting word index. Slot k occupies `line_data_o[k*WORD_W +: WORD_W]`.
- R7: If the beat with index LINE_WORDS-1 carries `beat_last_i`, then `line_done_o` is 1 for exactly the cycle after its handshake, `busy_o` is 0 in that cycle, and `line_data_o` holds the whole line.
- R8: If `beat_last_i` arrives on an earlier beat, or beat LINE_WORDS-1 arrives without it, then `len_err_o` is 1 for the cycle after that handshake, `line_done_o` stays 0 and the fill ends.
- R9: Cycles in which `beat_valid_i` is 0 during a fill do not advance the beat count and write no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fill (honoured only while idle) |
| miss_addr_i | input | ADDR_W | Byte address of the missed word |
| beat_valid_i | input | 1 | Data beat valid |
| beat_data_i | input | WORD_W | Data beat payload |
| beat_last_i | input | 1 | Marks the final beat of the burst |
| beat_ready_o | output | 1 | Beat accepted when high together with valid |
| busy_o | output | 1 | A fill is in progress |
| crit_valid_o | output | 1 | Critical word strobe |
| crit_data_o | output | WORD_W | Critical word |
| line_done_o | output | 1 | Line complete strobe |
| line_data_o | output | LINE_WORDS*WORD_W | Assembled line, slot 0 in the low bits |
| line_base_o | output | ADDR_W | Line-aligned base address of the fill |
| len_err_o | output | 1 | Last flag came at the wrong beat count |

## Verification
Fills are run from every starting slot: 0, the middle of the line, the last slot, and an address with byte-offset bits set. Each beat carries a distinct value, so a slot computed without the modulo, shifted by one, or taken from a byte offset shows up as a swapped or missing word. Some fills insert idle cycles between beats, which separates counting handshakes from counting cycles. Directed cases send an early last flag, leave out the last flag, and pulse start mid-fill; these separate the done, error and refusal paths.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic {FILL_IDLE = 1'b0, FILL_RUN = 1'b1} fill_state_e;
endpackage

// File: rtl/cwf_fill_ctrl.sv
module cwf_fill_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W      = $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int LINE_OFF_W = OFF_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              beat_valid_i,
  input  logic              beat_last_i,
  output logic              busy_o,
  output logic              fire_o,
  output logic              first_o,
  output logic [IDX_W-1:0]  start_idx_o,
  output logic [IDX_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              done_o,
  output logic              err_o
);
  import cwf_pkg::*;

  fill_state_e       state_q;
  logic [IDX_W-1:0]  start_idx_q, cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              done_q, err_q;
  logic              final_beat;

  assign busy_o      = (state_q == FILL_RUN);
  assign fire_o      = busy_o && beat_valid_i;
  assign first_o     = (cnt_q == '0);
  assign final_beat  = (cnt_q == IDX_W'(LINE_WORDS - 1));
  assign start_idx_o = start_idx_q;
  assign cnt_o       = cnt_q;
  assign base_o      = base_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= FILL_IDLE;
      start_idx_q <= '0;
      cnt_q       <= '0;
      base_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        FILL_IDLE: begin
          if (start_i) begin
            state_q     <= FILL_RUN;
            start_idx_q <= miss_addr_i[LINE_OFF_W-1:OFF_W];
            base_q      <= {miss_addr_i[ADDR_W-1:LINE_OFF_W], {LINE_OFF_W{1'b0}}};
            cnt_q       <= '0;
          end
        end
        FILL_RUN: begin
          if (fire_o) begin
            cnt_q <= cnt_q + 1'b1;
            // burst ends on the last flag or on the final slot, whichever first
            if (beat_last_i || final_beat) begin
              state_q <= FILL_IDLE;
              done_q  <= beat_last_i && final_beat;
              err_q   <= beat_last_i ^ final_beat;
            end
          end
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_slot_map.sv
module cwf_slot_map #(
  parameter int LINE_WORDS = 4,
  localparam int IDX_W = $clog2(LINE_WORDS)
) (
  input  logic [IDX_W-1:0]      start_idx_i,
  input  logic [IDX_W-1:0]      cnt_i,
  input  logic                  fire_i,
  output logic [LINE_WORDS-1:0] wen_o
);
  logic [IDX_W-1:0] slot;

  // IDX_W-bit sum gives the modulo-line wrap
  assign slot = start_idx_i + cnt_i;

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_dec
    assign wen_o[k] = fire_i && (slot == IDX_W'(k));
  end
endmodule

// File: rtl/cwf_line_store.sv
module cwf_line_store #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LINE_WORDS-1:0] wen_i,
  input  logic [WORD_W-1:0]     wdata_i,
  output logic [LINE_W-1:0]     line_o
);
  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       word_q <= '0;
      else if (wen_i[k]) word_q <= wdata_i;
    end
    assign line_o[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WORD_BYTES = WORD_W / 8,
  localparam int IDX_W      = $clog2(LINE_WORDS),
  localparam int LINE_W     = WORD_W * LINE_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              beat_valid_i,
  input  logic [WORD_W-1:0] beat_data_i,
  input  logic              beat_last_i,
  output logic              beat_ready_o,
  output logic              busy_o,
  output logic              crit_valid_o,
  output logic [WORD_W-1:0] crit_data_o,
  output logic              line_done_o,
  output logic [LINE_W-1:0] line_data_o,
  output logic [ADDR_W-1:0] line_base_o,
  output logic              len_err_o
);
  logic                  fire, first;
  logic [IDX_W-1:0]      start_idx, cnt;
  logic [LINE_WORDS-1:0] wen;

  cwf_fill_ctrl #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .miss_addr_i, .beat_valid_i, .beat_last_i,
    .busy_o      (busy_o),
    .fire_o      (fire),
    .first_o     (first),
    .start_idx_o (start_idx),
    .cnt_o       (cnt),
    .base_o      (line_base_o),
    .done_o      (line_done_o),
    .err_o       (len_err_o)
  );

  cwf_slot_map #(.LINE_WORDS(LINE_WORDS)) u_map (
    .start_idx_i (start_idx),
    .cnt_i       (cnt),
    .fire_i      (fire),
    .wen_o       (wen)
  );

  cwf_line_store #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_store (
    .clk_i, .rst_ni,
    .wen_i   (wen),
    .wdata_i (beat_data_i),
    .line_o  (line_data_o)
  );

  assign beat_ready_o = busy_o;
  assign crit_valid_o = fire && first;
  assign crit_data_o  = beat_data_i;
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              beat_valid_i,
  input logic [WORD_W-1:0] beat_data_i,
  input logic              beat_last_i,
  input logic              beat_ready_o,
  input logic              busy_o,
  input logic              crit_valid_o,
  input logic [WORD_W-1:0] crit_data_o,
  input logic              line_done_o,
  input logic [ADDR_W-1:0] line_base_o,
  input logic              len_err_o
);
  assert_start_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && beat_ready_o));

  assert_busy_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> $stable(line_base_o));

  assert_crit_at_handshake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |-> (beat_valid_i && beat_ready_o && crit_data_o == beat_data_i));

  assert_crit_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_valid_o |=> !crit_valid_o);

  assert_done_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> ($past(beat_valid_i && beat_ready_o && beat_last_i) && !busy_o));

  assert_done_err_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_done_o && len_err_o));

  assert_err_ends_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> (!busy_o && $past(beat_valid_i && beat_ready_o)));
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .beat_valid_i (beat_valid_i),
  .beat_data_i  (beat_data_i),
  .beat_last_i  (beat_last_i),
  .beat_ready_o (beat_ready_o),
  .busy_o       (busy_o),
  .crit_valid_o (crit_valid_o),
  .crit_data_o  (crit_data_o),
  .line_done_o  (line_done_o),
  .line_base_o  (line_base_o),
  .len_err_o    (len_err_o)
);

// File: tb/cwf_line_fill_tb.sv
module cwf_line_fill_tb;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int LW     = 4;
  localparam int LINE_W = WORD_W * LW;
  localparam int NVEC   = 6;

  // {miss address, data seed, insert idle gaps}
  localparam logic [ADDR_W-1:0] VEC_ADDR [NVEC] = '{32'h08, 32'h00, 32'h0C, 32'h107, 32'h1234, 32'hFFFF_FFF6};
  localparam logic [WORD_W-1:0] VEC_SEED [NVEC] = '{32'hA000, 32'hB100, 32'hC200, 32'hD300, 32'hE400, 32'hF500};
  localparam logic              VEC_GAP  [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] miss_addr_i = '0;
  logic              beat_valid_i = 1'b0;
  logic [WORD_W-1:0] beat_data_i = '0;
  logic              beat_last_i = 1'b0;
  logic              beat_ready_o, busy_o, crit_valid_o, line_done_o, len_err_o;
  logic [WORD_W-1:0] crit_data_o;
  logic [LINE_W-1:0] line_data_o;
  logic [ADDR_W-1:0] line_base_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_i = ~clk_i;

  cwf_line_fill #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LW)) u_dut (.*);

  task automatic check(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] exp_line(input int s, input logic [WORD_W-1:0] seed);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < LW; k++) l[k*WORD_W +: WORD_W] = seed + WORD_W'((k - s + LW) % LW);
    return l;
  endfunction

  task automatic begin_fill(input logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    start_i = 1'b1; miss_addr_i = a;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy", LINE_W'(busy_o), 1);
    check("R4 ready", LINE_W'(beat_ready_o), 1);
    check("R2 base", LINE_W'(line_base_o), LINE_W'(a & ~32'hF));
  endtask

  // drive beat n at negedge, look at the combinational outputs, let it be taken at the posedge
  task automatic send_beat(input int n, input logic [WORD_W-1:0] d, input logic last);
    beat_valid_i = 1'b1; beat_data_i = d; beat_last_i = last;
    #1;
    check("R4 ready in fill", LINE_W'(beat_ready_o), 1);
    check("R5 crit strobe", LINE_W'(crit_valid_o), LINE_W'(n == 0));
    if (n == 0) check("R5 crit data", LINE_W'(crit_data_o), LINE_W'(d));
    @(negedge clk_i);
    beat_valid_i = 1'b0; beat_last_i = 1'b0;
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R1 busy", LINE_W'(busy_o), 0);
    check("R1 ready", LINE_W'(beat_ready_o), 0);
    check("R1 strobes", LINE_W'({crit_valid_o, line_done_o, len_err_o}), 0);
    check("R1 line", line_data_o, '0);
    check("R1 base", LINE_W'(line_base_o), 0);
    #11 rst_ni = 1'b1;

    // vector walk: R2 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      int s;
      s = int'(VEC_ADDR[v][3:2]);
      begin_fill(VEC_ADDR[v]);
      for (int n = 0; n < LW; n++) begin
        if (VEC_GAP[v] && n > 0) begin
          @(negedge clk_i);
          check("R9 no write on idle cycle", LINE_W'(line_done_o | len_err_o), 0);
        end
        send_beat(n, VEC_SEED[v] + WORD_W'(n), n == LW - 1);
      end
      check("R7 done", LINE_W'(line_done_o), 1);
      check("R7 busy low", LINE_W'(busy_o), 0);
      check("R8 no err", LINE_W'(len_err_o), 0);
      check("R6 slots", line_data_o, exp_line(s, VEC_SEED[v]));
      @(negedge clk_i);
      check("R7 done one cycle", LINE_W'(line_done_o), 0);
    end

    // R3: start mid-fill ignored
    begin_fill(32'h48);
    send_beat(0, 32'h5000, 1'b0);
    start_i = 1'b1; miss_addr_i = 32'h84;
    send_beat(1, 32'h5001, 1'b0);
    start_i = 1'b0;
    check("R3 base kept", LINE_W'(line_base_o), LINE_W'(32'h40));
    send_beat(2, 32'h5002, 1'b0);
    send_beat(3, 32'h5003, 1'b1);
    check("R3 done", LINE_W'(line_done_o), 1);
    check("R3 slots of original start", line_data_o, exp_line(2, 32'h5000));
    @(negedge clk_i);

    // R8: early last flag
    begin_fill(32'h24);
    send_beat(0, 32'h6000, 1'b0);
    send_beat(1, 32'h6001, 1'b1);
    check("R8 early last err", LINE_W'(len_err_o), 1);
    check("R8 early last no done", LINE_W'(line_done_o), 0);
    check("R8 fill ended", LINE_W'(busy_o), 0);
    @(negedge clk_i);
    check("R8 err one cycle", LINE_W'(len_err_o), 0);

    // R8: missing last flag
    begin_fill(32'h30);
    for (int n = 0; n < LW; n++) send_beat(n, 32'h7000 + WORD_W'(n), 1'b0);
    check("R8 missing last err", LINE_W'(len_err_o), 1);
    check("R8 missing last no done", LINE_W'(line_done_o), 0);
    check("R8 missing last ended", LINE_W'(busy_o), 0);
    @(negedge clk_i);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule